// File: doc/BRIEF.md
# Open-Row Line Prefetcher

This block sits next to the controller of a single DRAM bank. While a row is open it keeps a record of which cache-line columns of that row demand reads have touched. When the controller signals that it intends to close the row, the block walks the columns that are still untouched, from the lowest upward. It issues each one as a prefetch column request over a valid/ready handshake, so that the line can be written into the L2 before the row is closed.

Prefetching has to give way to demand traffic that targets other rows. A mode input selects how this happens. In demand-first mode, any pending demand for another row ends prefetching at once. In batch mode, prefetching continues while the number of such pending demands is below a programmable threshold, and the block tells the controller to hold those demands back. A permission output tells the controller when the row may be closed. The DRAM timing engine and the L2 fill path are outside the block.

Top module: `opf_top`

## Requirements
- R1: After reset, `pf_valid_o`, `close_ok_o` and `hold_dmd_o` are all low.
- R2: A `row_open_i` pulse starts a new row. It clears the record of touched columns, so all 32 columns are candidates again. It also drops `close_ok_o` on the next cycle.
- R3: While a row is open, each demand (`dmd_valid_i` with column `dmd_col_i`) marks that column as touched, starting from the cycle after it is presented.
- R4: Prefetch requests appear only after a `close_req_i` pulse for the open row. They name only columns that are neither demand-touched nor already prefetched, and no column is issued twice for the same row.
- R5: The column offered on `pf_col_o` is always the lowest untouched column, so the accepted prefetches of a row are strictly ascending.
- R6: While `pf_ready_i` is low, the offered column stays the same. The block moves to the next untouched column only after a cycle in which valid and ready are both high.
- R7: A demand to the column currently on offer removes it from the candidates. From the next cycle the next untouched column is offered instead.
- R8: Mode 0 (`mode_i` = 0): if `other_pend_i` is non-zero, `pf_valid_o` goes low in that same cycle, and `close_ok_o` rises on the next cycle.
- R9: Mode 1 (`mode_i` = 1): while `other_pend_i` < `thresh_i`, prefetching continues and `hold_dmd_o` is high. When `other_pend_i` >= `thresh_i`, valid and hold drop in that cycle and `close_ok_o` rises on the next cycle.
- R10: When all 32 columns are covered, `pf_valid_o` is low and `close_ok_o` rises one cycle later. This includes a row whose columns were all demand-read before the close request.
- R11: Once `close_ok_o` is high it stays high, and no further prefetch is offered, until the next `row_open_i`. This holds even if the pending count later falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_open_i | input | 1 | Pulse: a new row has been opened |
| close_req_i | input | 1 | Pulse: the controller intends to close the open row |
| dmd_valid_i | input | 1 | Demand read to the open row |
| dmd_col_i | input | 5 | Column of the demand read |
| other_pend_i | input | 8 | Number of pending demands for other rows |
| mode_i | input | 1 | 0: demand-first cut-off, 1: threshold-based holding |
| thresh_i | input | 8 | Pending-count threshold used in mode 1 |
| pf_valid_o | output | 1 | Prefetch request valid |
| pf_col_o | output | 5 | Column to prefetch |
| pf_ready_i | input | 1 | Prefetch request accepted |
| hold_dmd_o | output | 1 | Demands for other rows must wait |
| close_ok_o | output | 1 | The row may be closed |

## Verification
Three kinds of result are due at different times. A close request, a demand mark or a handshake changes the offered column in the cycle after its clock edge. A change on `other_pend_i` or `mode_i` acts on `pf_valid_o` and `hold_dmd_o` in the same cycle. `close_ok_o` rises one edge after the stop condition or after the record becomes full. The bench drives every input just after a rising edge. It reads the combinational outputs one time step after driving, and reads registered results only after the next edge. Each scenario task keeps its own model of the touched columns and compares every offered column against the lowest gap in that model.

// File: rtl/opf_pkg.sv
// Package: shared types for the open-row prefetcher.
// Assumes: included before every other opf_* file.
package opf_pkg;

    // Life of one open row, as seen by the prefetcher.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // no row open
        ST_TRACK = 2'd1,   // row open, recording demand columns
        ST_PREF  = 2'd2,   // close intent seen, issuing prefetches
        ST_DONE  = 2'd3    // row may be closed
    } opf_state_e;

endpackage

// File: rtl/opf_line_map.sv
// Module: opf_line_map
// Keeps one bit per cache-line column of the open row. A bit is set when
// a demand reads the column or a prefetch for it is accepted.
// Assumes: clear_i has priority over all marks; marks are ignored while
// track_i is low.
module opf_line_map #(
    parameter int COLS  = 32,
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             track_i,
    input  logic             dmd_valid_i,
    input  logic [COL_W-1:0] dmd_col_i,
    input  logic             pf_fire_i,
    input  logic [COL_W-1:0] pf_col_i,
    output logic [COLS-1:0]  map_o,
    output logic             full_o
);

    logic [COLS-1:0] map_q;
    logic [COLS-1:0] set_vec;

    // Per-column set requests from demand and prefetch handshake.
    for (genvar g = 0; g < COLS; g++) begin : g_set
        assign set_vec[g] = track_i &&
                            ((dmd_valid_i && (dmd_col_i == COL_W'(g))) ||
                             (pf_fire_i   && (pf_col_i  == COL_W'(g))));
    end

    // Bitmap register: clear on new row, otherwise accumulate marks.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            map_q <= '0;
        end else begin
            map_q <= map_q | set_vec;
        end
    end

    assign map_o  = map_q;
    assign full_o = &map_q;

    AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        pf_fire_i |-> !map_q[pf_col_i]);                              // R4

    AST_MARK_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (track_i && !clear_i && dmd_valid_i) |=> map_q[$past(dmd_col_i)]); // R3

endmodule

// File: rtl/opf_first_free.sv
// Module: opf_first_free
// Finds the lowest column whose bit is clear. Since bits are only ever
// set within a row, this index moves strictly upward and acts as the
// sequential prefetch pointer.
// Assumes: col_o is don't-care when any_o is low.
module opf_first_free #(
    parameter int COLS  = 32,
    localparam int COL_W = $clog2(COLS)
) (
    input  logic [COLS-1:0]  map_i,
    output logic [COL_W-1:0] col_o,
    output logic             any_o
);

    logic [COLS:0] seen;   // seen[i]: a clear bit exists below column i

    assign seen[0] = 1'b0;
    for (genvar g = 0; g < COLS; g++) begin : g_chain
        assign seen[g+1] = seen[g] | ~map_i[g];
    end

    // Encode the first column where the chain turns on.
    always_comb begin
        col_o = '0;
        for (int i = 0; i < COLS; i++) begin
            if (!seen[i] && !map_i[i]) begin
                col_o = COL_W'(i);
            end
        end
    end

    assign any_o = seen[COLS];

endmodule

// File: rtl/opf_ctrl.sv
// Module: opf_ctrl
// Row life-cycle state machine and the mode-dependent stop rule.
// Assumes: row_open_i and close_req_i are single-cycle pulses from the
// bank controller; other_pend_i counts demands for rows other than this one.
module opf_ctrl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_open_i,
    input  logic             close_req_i,
    input  logic [CNT_W-1:0] other_pend_i,
    input  logic             mode_i,
    input  logic [CNT_W-1:0] thresh_i,
    input  logic             full_i,
    input  logic             any_free_i,
    output logic             track_o,
    output logic             pf_valid_o,
    output logic             hold_dmd_o,
    output logic             close_ok_o
);
    import opf_pkg::*;

    opf_state_e state_q, state_d;
    logic       stop_now;
    logic       active;

    // Stop rule: mode 0 yields to any other-row demand, mode 1 at threshold.
    always_comb begin
        if (mode_i) begin
            stop_now = (other_pend_i >= thresh_i);
        end else begin
            stop_now = (other_pend_i != '0);
        end
    end

    assign active = (state_q == ST_PREF) && any_free_i && !stop_now;

    // Next-state selection for the row life cycle.
    always_comb begin
        state_d = state_q;
        if (row_open_i) begin
            state_d = ST_TRACK;
        end else begin
            case (state_q)
                ST_TRACK: if (close_req_i)         state_d = ST_PREF;
                ST_PREF:  if (full_i || stop_now)  state_d = ST_DONE;
                default:  state_d = state_q;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign track_o    = (state_q != ST_IDLE) && !row_open_i;
    assign pf_valid_o = active;
    assign hold_dmd_o = active && mode_i;
    assign close_ok_o = (state_q == ST_DONE);

    AST_CLOSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (close_ok_o && !row_open_i) |=> close_ok_o);                  // R11

    AST_OPEN_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        row_open_i |=> (!close_ok_o && !pf_valid_o));                 // R2

    AST_HOLD_MODE1: assert property (@(posedge clk) disable iff (!rst_n)
        hold_dmd_o |-> (mode_i && pf_valid_o));                       // R9

    AST_NO_PF_WHEN_CLOSABLE: assert property (@(posedge clk) disable iff (!rst_n)
        close_ok_o |-> !pf_valid_o);                                  // R11

endmodule

// File: rtl/opf_top.sv
// Module: opf_top
// Open-row prefetcher for one DRAM bank: records demand columns of the
// open row and, on close intent, offers the untouched columns in
// ascending order until done or stopped by the mode rule.
// Assumes: one bank, one open row at a time; a demand presented in the
// same cycle as row_open_i belongs to the old row and is dropped.
module opf_top #(
    parameter int COLS  = 32,
    parameter int CNT_W = 8,
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_open_i,
    input  logic             close_req_i,
    input  logic             dmd_valid_i,
    input  logic [COL_W-1:0] dmd_col_i,
    input  logic [CNT_W-1:0] other_pend_i,
    input  logic             mode_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic             pf_valid_o,
    output logic [COL_W-1:0] pf_col_o,
    input  logic             pf_ready_i,
    output logic             hold_dmd_o,
    output logic             close_ok_o
);

    logic [COLS-1:0]  map;
    logic             full;
    logic             any_free;
    logic             track;
    logic             pf_fire;
    logic [COL_W-1:0] next_col;

    assign pf_fire  = pf_valid_o && pf_ready_i;
    assign pf_col_o = next_col;

    opf_line_map #(.COLS(COLS)) map_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (row_open_i),
        .track_i     (track),
        .dmd_valid_i (dmd_valid_i),
        .dmd_col_i   (dmd_col_i),
        .pf_fire_i   (pf_fire),
        .pf_col_i    (next_col),
        .map_o       (map),
        .full_o      (full)
    );

    opf_first_free #(.COLS(COLS)) ff_i (
        .map_i (map),
        .col_o (next_col),
        .any_o (any_free)
    );

    opf_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .row_open_i   (row_open_i),
        .close_req_i  (close_req_i),
        .other_pend_i (other_pend_i),
        .mode_i       (mode_i),
        .thresh_i     (thresh_i),
        .full_i       (full),
        .any_free_i   (any_free),
        .track_o      (track),
        .pf_valid_o   (pf_valid_o),
        .hold_dmd_o   (hold_dmd_o),
        .close_ok_o   (close_ok_o)
    );

    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_fire && !row_open_i) |=> (!pf_valid_o || (pf_col_o > $past(pf_col_o)))); // R5

    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid_o && !pf_ready_i && !dmd_valid_i && !row_open_i)
        |=> (!pf_valid_o || $stable(pf_col_o)));                      // R6

    AST_MODE0_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid_o && !mode_i && (other_pend_i != '0)) |-> 1'b0);    // R8

endmodule

// File: tb/opf_top_tb_top.sv
// Directed bench for opf_top: one task per scenario, each self-checking.
module opf_top_tb_top;

    localparam int COLS  = 32;
    localparam int COL_W = 5;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             row_open_i, close_req_i, dmd_valid_i, mode_i, pf_ready_i;
    logic [COL_W-1:0] dmd_col_i;
    logic [CNT_W-1:0] other_pend_i, thresh_i;
    logic             pf_valid_o, hold_dmd_o, close_ok_o;
    logic [COL_W-1:0] pf_col_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [COLS-1:0] exp_map;

    always #5 clk = ~clk;

    opf_top #(.COLS(COLS), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .row_open_i(row_open_i), .close_req_i(close_req_i),
        .dmd_valid_i(dmd_valid_i), .dmd_col_i(dmd_col_i), .other_pend_i(other_pend_i),
        .mode_i(mode_i), .thresh_i(thresh_i), .pf_valid_o(pf_valid_o),
        .pf_col_o(pf_col_o), .pf_ready_i(pf_ready_i), .hold_dmd_o(hold_dmd_o),
        .close_ok_o(close_ok_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lowest_gap(input logic [COLS-1:0] m);
        for (int i = 0; i < COLS; i++) if (!m[i]) return i;
        return -1;
    endfunction

    task automatic open_row();
        row_open_i = 1'b1; tick(); row_open_i = 1'b0;
        exp_map = '0;
    endtask

    task automatic hit(input int col);
        dmd_valid_i = 1'b1; dmd_col_i = COL_W'(col); tick();
        dmd_valid_i = 1'b0;
        exp_map[col] = 1'b1;
    endtask

    task automatic ask_close();
        close_req_i = 1'b1; tick(); close_req_i = 1'b0;
    endtask

    // Accept every offered column until the model is full.
    task automatic drain(input string req);
        pf_ready_i = 1'b1;
        while (lowest_gap(exp_map) >= 0) begin
            chk({req, " valid"}, pf_valid_o, 1);
            chk({req, " col"}, pf_col_o, lowest_gap(exp_map));
            exp_map[pf_col_o] = 1'b1;
            tick();
        end
        pf_ready_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 valid", pf_valid_o, 0);
        chk("R1 close_ok", close_ok_o, 0);
        chk("R1 hold", hold_dmd_o, 0);
    endtask

    task automatic t_basic();
        open_row();
        hit(0); hit(2); hit(5);
        chk("R4 no prefetch before close", pf_valid_o, 0);
        ask_close();
        drain("R3 R4 R5");
        chk("R10 valid low when full", pf_valid_o, 0);
        chk("R10 close_ok not yet", close_ok_o, 0);
        tick();
        chk("R10 close_ok", close_ok_o, 1);
    endtask

    task automatic t_stall();
        open_row(); ask_close();
        for (int k = 0; k < 3; k++) begin
            chk("R6 stall valid", pf_valid_o, 1);
            chk("R6 stall col", pf_col_o, 0);
            tick();
        end
        pf_ready_i = 1'b1; tick(); pf_ready_i = 1'b0;
        chk("R6 advance after handshake", pf_col_o, 1);
    endtask

    task automatic t_hit_pending();
        open_row(); ask_close();
        chk("R7 offered col", pf_col_o, 0);
        hit(0);
        chk("R7 skip hit col", pf_col_o, 1);
        hit(4);
        drain("R7 R4");
        tick();
        chk("R7 close_ok", close_ok_o, 1);
    endtask

    task automatic t_mode0();
        mode_i = 1'b0;
        open_row(); ask_close();
        pf_ready_i = 1'b1; tick(); tick(); pf_ready_i = 1'b0;
        chk("R8 col before cut", pf_col_o, 2);
        other_pend_i = 8'd1; #1;
        chk("R8 cut same cycle", pf_valid_o, 0);
        tick();
        chk("R8 close_ok next", close_ok_o, 1);
        other_pend_i = 8'd0; tick();
        chk("R11 no resume", pf_valid_o, 0);
        chk("R11 close_ok held", close_ok_o, 1);
    endtask

    task automatic t_mode1();
        mode_i = 1'b1; thresh_i = 8'd3; other_pend_i = 8'd2;
        open_row(); ask_close();
        chk("R9 below thresh valid", pf_valid_o, 1);
        chk("R9 hold", hold_dmd_o, 1);
        other_pend_i = 8'd3; #1;
        chk("R9 at thresh valid", pf_valid_o, 0);
        chk("R9 at thresh hold", hold_dmd_o, 0);
        tick();
        chk("R9 close_ok", close_ok_o, 1);
        other_pend_i = 8'd0; mode_i = 1'b0;
    endtask

    task automatic t_all_hit();
        open_row();
        for (int c = 0; c < COLS; c++) hit(c);
        ask_close();
        chk("R10 nothing to prefetch", pf_valid_o, 0);
        chk("R10 close_ok pending", close_ok_o, 0);
        tick();
        chk("R10 close_ok", close_ok_o, 1);
    endtask

    task automatic t_reopen();
        open_row();
        chk("R2 close_ok cleared", close_ok_o, 0);
        ask_close();
        chk("R2 record cleared valid", pf_valid_o, 1);
        chk("R2 record cleared col", pf_col_o, 0);
    endtask

    initial begin
        rst_n = 1'b0; row_open_i = 0; close_req_i = 0; dmd_valid_i = 0;
        dmd_col_i = '0; other_pend_i = '0; mode_i = 0; thresh_i = 8'd4;
        pf_ready_i = 0; exp_map = '0;
        tick(); tick();
        t_reset();
        rst_n = 1'b1; tick();
        t_reset();
        t_basic();
        t_stall();
        t_hit_pending();
        t_mode0();
        t_mode1();
        t_all_hit();
        t_reopen();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule